// File: doc/BRIEF.md
# Debug Breakpoint Qualification Unit

This block sits between the watchpoint comparators of a processor core and the core's debug exception entry. Each cycle it receives one match pulse per watchpoint. It decides which pulses become a breakpoint request and merges them with breakpoint requests that arrive from outside the core. A watchpoint can be set up as a trap, which raises a request on every qualifying pulse. It can instead be set up as a counted trap, which raises a request only after a preset number of qualifying pulses. The trap enable for each watchpoint has two sources: a software bit and a debug-port bit. The trap is armed when either bit is set.

Masking depends on a restartability status input from the core. In masked mode a breakpoint is taken only while that input is high. Each watchpoint can be switched to a non-masked mode, in which the status input is ignored. An external maskable request follows the same masking rule. A non-maskable external request is always taken. The raw watchpoint pulses are copied to output pins with no masking at all. The core reads the counters through a read-select port and acknowledges a breakpoint with a single pulse.

Top module: `dbg_bkpt_qual`

## Requirements
- R1: `wp_pins_o` equals the value of `wp_i` at the previous rising clock edge. Trap enables, modes and `ri_i` have no effect on it.
- R2: The trap for watchpoint k is armed when bit k written at address 0 (software enable) or bit k written at address 1 (debug-port enable) is 1. While both bits are 0, watchpoint k never raises a request.
- R3: In immediate mode, a qualifying pulse on an armed watchpoint raises `bkpt_req_o` at the next rising edge. A watchpoint is in immediate mode when it has no counter, or when its counted-mode bit (address 2, bit k, which exists for k < 2 only) is 0.
- R4: In masked mode (bit k at address 3 is 0), a pulse on watchpoint k while `ri_i` is 0 raises no request.
- R5: With non-masked mode selected (bit k at address 3 is 1), a pulse on an armed watchpoint k raises a request even while `ri_i` is 0.
- R6: Counter k (k < 2) belongs to watchpoint k. It is loaded by a write to address 4+k. In counted mode it drops by one on each qualifying pulse of watchpoint k, whether or not the trap is armed. The pulse that takes it from 1 to 0 raises a request if the trap is armed. It then stays at 0 until it is reloaded. In immediate mode it keeps its value.
- R7: A counter does not change on a pulse of its watchpoint while that watchpoint is in masked mode and `ri_i` is 0.
- R8: `ext_bkpt_i` raises a request only while `ri_i` is 1. `ext_nm_bkpt_i` raises a request whatever the value of `ri_i`.
- R9: `bkpt_req_o` stays high until a cycle with `bkpt_ack_i` high. That acknowledge clears every pending request, unless a new qualifying request arrives in the same cycle, in which case `bkpt_req_o` stays high.
- R10: `cnt_rd_o` shows the current value of the counter selected by `rd_sel_i`, with no added delay.
- R11: After reset, `bkpt_req_o`, `wp_pins_o`, every enable and mode bit, and every counter are 0.
- R12: A counter write in the same cycle as a qualifying pulse of its watchpoint loads the written value and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | NUM_WP | Watchpoint match pulses, one bit per watchpoint |
| ri_i | input | 1 | Machine-restartable status from the core |
| ext_bkpt_i | input | 1 | External maskable breakpoint request |
| ext_nm_bkpt_i | input | 1 | External non-maskable breakpoint request |
| bkpt_ack_i | input | 1 | Breakpoint acknowledge from the core |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_sel_i | input | CSEL_W | Counter read select |
| cnt_rd_o | output | CNT_W | Selected counter value |
| wp_pins_o | output | NUM_WP | Registered copy of the watchpoint pulses |
| bkpt_req_o | output | 1 | Pending breakpoint request level |

## Verification
The assertions assume that `ri_i`, the watchpoint pulses and all control inputs are synchronous and settled at each rising edge. They also assume that a counter write and its preload value are presented in the same cycle. The bench drives every input at the falling edge, and each stimulus call holds its values for exactly one rising edge before returning them to idle. Writes, pulses and acknowledges therefore never straddle an edge. Corner cases such as a write that collides with a pulse, or an acknowledge that collides with a new hit, are built on purpose within that single-edge rule.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_SW_EN    = 3'd0;
  localparam logic [REG_AW-1:0] A_DP_EN    = 3'd1;
  localparam logic [REG_AW-1:0] A_CNT_MODE = 3'd2;
  localparam logic [REG_AW-1:0] A_NOMASK   = 3'd3;
  localparam logic [REG_AW-1:0] A_CNT_BASE = 3'd4;
endpackage

// File: rtl/dbg_bkpt_cfg.sv
module dbg_bkpt_cfg
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_WP  = 4,
  parameter int NUM_CNT = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_AW-1:0]    wr_addr_i,
  input  logic [NUM_WP-1:0]    wr_data_i,
  output logic [NUM_WP-1:0]    sw_en_o,
  output logic [NUM_WP-1:0]    dp_en_o,
  output logic [NUM_WP-1:0]    nomask_o,
  output logic [NUM_CNT-1:0]   cnt_mode_o,
  output logic [NUM_CNT-1:0]   cnt_load_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_o    <= '0;
      dp_en_o    <= '0;
      nomask_o   <= '0;
      cnt_mode_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_SW_EN:    sw_en_o    <= wr_data_i;
        A_DP_EN:    dp_en_o    <= wr_data_i;
        A_NOMASK:   nomask_o   <= wr_data_i;
        A_CNT_MODE: cnt_mode_o <= wr_data_i[NUM_CNT-1:0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_load
    assign cnt_load_o[k] = wr_en_i && (wr_addr_i == REG_AW'(int'(A_CNT_BASE) + k));
  end

  p_sw_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SW_EN) |=> sw_en_o == $past(wr_data_i));
  p_dp_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_DP_EN) |=> dp_en_o == $past(wr_data_i));
  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(sw_en_o) && $stable(dp_en_o) && $stable(nomask_o)));

endmodule

// File: rtl/dbg_wp_counter.sv
module dbg_wp_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             mode_i,
  input  logic             wp_i,
  input  logic             ri_i,
  input  logic             nomask_i,
  input  logic             trap_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             qual;
  logic             dec;

  assign qual   = wp_i && (nomask_i || ri_i);
  assign dec    = mode_i && qual && !load_i && (cnt_q != '0);
  assign fire_o = dec && trap_en_i && (cnt_q == CNT_W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec)    cnt_q <= cnt_q - CNT_W'(1);
  end

  p_masked_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !ri_i && !nomask_i) |=> $stable(cnt_q));
  p_zero_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
  p_imm_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !mode_i) |=> $stable(cnt_q));
  p_load_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  p_no_fire_on_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !fire_o);

endmodule

// File: rtl/dbg_bkpt_merge.sv
module dbg_bkpt_merge #(
  parameter int NUM_WP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WP-1:0] hit_i,
  input  logic              ext_i,
  input  logic              ext_nm_i,
  input  logic              ri_i,
  input  logic              ack_i,
  output logic              req_o
);

  logic req_q;
  logic any_hit;

  assign any_hit = (|hit_i) || (ext_i && ri_i) || ext_nm_i;
  assign req_o   = req_q;

  // a new hit in the acknowledge cycle keeps the request up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= any_hit || (req_q && !ack_i);
  end

  p_hit_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_i) |=> req_q);
  p_nm_ext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_nm_i |=> req_q);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);
  p_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && hit_i == '0 && !ext_i && !ext_nm_i) |=> !req_q);
  p_ext_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q && hit_i == '0 && !ext_nm_i && !ri_i) |=> !req_q);

endmodule

// File: rtl/dbg_bkpt_qual.sv
module dbg_bkpt_qual
  import dbg_bkpt_pkg::*;
#(
  parameter int NUM_WP  = 4,
  parameter int NUM_CNT = 2,
  parameter int CNT_W   = 16,
  localparam int CSEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WP-1:0] wp_i,
  input  logic              ri_i,
  input  logic              ext_bkpt_i,
  input  logic              ext_nm_bkpt_i,
  input  logic              bkpt_ack_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [CSEL_W-1:0] rd_sel_i,
  output logic [CNT_W-1:0]  cnt_rd_o,
  output logic [NUM_WP-1:0] wp_pins_o,
  output logic              bkpt_req_o
);

  logic [NUM_WP-1:0]  sw_en, dp_en, nomask, hit;
  logic [NUM_CNT-1:0] cnt_mode, cnt_load;
  logic [CNT_W-1:0]   cnt_val [NUM_CNT];

  dbg_bkpt_cfg #(.NUM_WP(NUM_WP), .NUM_CNT(NUM_CNT)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i[NUM_WP-1:0]),
    .sw_en_o    (sw_en),
    .dp_en_o    (dp_en),
    .nomask_o   (nomask),
    .cnt_mode_o (cnt_mode),
    .cnt_load_o (cnt_load)
  );

  for (genvar k = 0; k < NUM_WP; k++) begin : g_wp
    logic trap_en, qual;
    assign trap_en = sw_en[k] | dp_en[k];
    assign qual    = wp_i[k] && (nomask[k] || ri_i);
    if (k < NUM_CNT) begin : g_counted
      logic fire;
      dbg_wp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load[k]),
        .load_val_i (wr_data_i),
        .mode_i     (cnt_mode[k]),
        .wp_i       (wp_i[k]),
        .ri_i       (ri_i),
        .nomask_i   (nomask[k]),
        .trap_en_i  (trap_en),
        .cnt_o      (cnt_val[k]),
        .fire_o     (fire)
      );
      assign hit[k] = fire || (!cnt_mode[k] && qual && trap_en);
    end else begin : g_direct
      assign hit[k] = qual && trap_en;
    end
  end

  dbg_bkpt_merge #(.NUM_WP(NUM_WP)) u_merge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .ext_i    (ext_bkpt_i),
    .ext_nm_i (ext_nm_bkpt_i),
    .ri_i     (ri_i),
    .ack_i    (bkpt_ack_i),
    .req_o    (bkpt_req_o)
  );

  always_comb begin
    cnt_rd_o = '0;
    if (int'(rd_sel_i) < NUM_CNT) cnt_rd_o = cnt_val[rd_sel_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_pins_o <= '0;
    else         wp_pins_o <= wp_i;
  end

  p_pins_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> wp_pins_o == $past(wp_i));
  p_disarmed_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sw_en | dp_en) == '0) |-> hit == '0);
  p_masked_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ri_i && nomask == '0) |-> hit == '0);

endmodule

// File: tb/dbg_bkpt_qual_tb_top.sv
`timescale 1ns/1ps
module dbg_bkpt_qual_tb_top;
  localparam int NW = 4;
  localparam int CW = 16;

  typedef struct {
    logic          req;
    logic [NW-1:0] pins;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] wp = '0;
  logic ri = 1'b0, ext = 1'b0, nmi = 1'b0, ack = 1'b0, we = 1'b0;
  logic [2:0] wa = '0;
  logic [CW-1:0] wd = '0;
  logic [0:0] rsel = '0;
  logic [CW-1:0] cnt_rd;
  logic [NW-1:0] pins;
  logic req;

  int total = 0;
  int bad = 0;
  exp_t sb_q[$];

  logic [NW-1:0] m_sw = '0, m_dp = '0, m_nm = '0;
  logic [1:0]    m_cm = '0;
  logic [CW-1:0] m_cnt [2] = '{default: '0};
  logic          m_pend = 1'b0;

  always #5 clk = ~clk;

  dbg_bkpt_qual dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wp_i          (wp),
    .ri_i          (ri),
    .ext_bkpt_i    (ext),
    .ext_nm_bkpt_i (nmi),
    .bkpt_ack_i    (ack),
    .wr_en_i       (we),
    .wr_addr_i     (wa),
    .wr_data_i     (wd),
    .rd_sel_i      (rsel),
    .cnt_rd_o      (cnt_rd),
    .wp_pins_o     (pins),
    .bkpt_req_o    (req)
  );

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // one cycle of stimulus; model computed from the requirements
  task automatic step(input logic [NW-1:0] w, input logic r, input logic e, input logic n,
                      input logic a, input logic wen, input logic [2:0] adr,
                      input logic [CW-1:0] dat, input string tag);
    logic hit;
    exp_t it;
    @(negedge clk);
    wp = w; ri = r; ext = e; nmi = n; ack = a; we = wen; wa = adr; wd = dat;
    hit = (e && r) || n;
    for (int k = 0; k < NW; k++) begin
      logic q, en;
      q  = w[k] && (m_nm[k] || r);
      en = m_sw[k] | m_dp[k];
      if (k < 2 && m_cm[k]) begin
        if (!(wen && adr == 3'(4 + k)) && q && m_cnt[k] != '0) begin
          if (m_cnt[k] == 1 && en) hit = 1'b1;
          m_cnt[k] = m_cnt[k] - 1'b1;
        end
      end else if (q && en) hit = 1'b1;
    end
    if (wen) begin
      case (adr)
        3'd0: m_sw = dat[NW-1:0];
        3'd1: m_dp = dat[NW-1:0];
        3'd2: m_cm = dat[1:0];
        3'd3: m_nm = dat[NW-1:0];
        3'd4: m_cnt[0] = dat;
        3'd5: m_cnt[1] = dat;
        default: ;
      endcase
    end
    m_pend = hit || (m_pend && !a);
    it.req = m_pend; it.pins = w; it.tag = tag;
    @(posedge clk);
    sb_q.push_back(it);
    #1;
    wp = '0; ext = 1'b0; nmi = 1'b0; ack = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] adr, input logic [CW-1:0] dat, input string tag);
    step('0, ri, 1'b0, 1'b0, 1'b0, 1'b1, adr, dat, tag);
  endtask

  task automatic chk_cnt(input int k, input logic [CW-1:0] exp_v, input string tag);
    @(negedge clk);
    rsel = 1'(k);
    #1;
    total++;
    if (cnt_rd !== exp_v) begin
      bad++;
      $display("FAIL %s: counter%0d actual=%0d expected=%0d", tag, k, cnt_rd, exp_v);
    end
  endtask

  // monitor: pops one expected item per produced cycle
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        total++;
        if (req !== it.req || pins !== it.pins) begin
          bad++;
          $display("FAIL %s: req=%b pins=%b expected req=%b pins=%b",
                   it.tag, req, pins, it.req, it.pins);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    total++;
    if (req !== 1'b0 || pins !== '0 || cnt_rd !== '0) begin
      bad++;
      $display("FAIL R11: req=%b pins=%b cnt=%0d expected 0 0 0", req, pins, cnt_rd);
    end
    chk_cnt(1, '0, "R11");

    // disarmed traps: pins still mirror
    step(4'b1111, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R1/R2 disarmed");
    step(4'b1010, 1'b0, 0, 0, 0, 0, 3'd0, '0, "R1 ri low");

    // immediate trap via software enable, held until ack
    wr(3'd0, 16'h0001, "R2 sw write");
    step(4'b0001, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R3 immediate");
    step(4'b0000, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R9 held");
    step(4'b0000, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R9 held2");
    step(4'b0000, 1'b1, 0, 0, 1, 0, 3'd0, '0, "R9 ack");

    // debug-port enable path
    wr(3'd0, 16'h0000, "R2 sw clear");
    wr(3'd1, 16'h0004, "R2 dp write");
    step(4'b0100, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R2 dp trap");
    step(4'b0000, 1'b1, 0, 0, 1, 0, 3'd0, '0, "R9 ack2");

    // masking
    step(4'b0100, 1'b0, 0, 0, 0, 0, 3'd0, '0, "R4 masked");
    wr(3'd3, 16'h0004, "R5 nomask write");
    step(4'b0100, 1'b0, 0, 0, 0, 0, 3'd0, '0, "R5 nonmasked");
    step(4'b0000, 1'b0, 0, 0, 1, 0, 3'd0, '0, "R9 ack3");

    // external requests
    step(4'b0000, 1'b0, 1, 0, 0, 0, 3'd0, '0, "R8 ext masked");
    step(4'b0000, 1'b1, 1, 0, 0, 0, 3'd0, '0, "R8 ext taken");
    step(4'b0000, 1'b1, 0, 0, 1, 0, 3'd0, '0, "R9 ack4");
    step(4'b0000, 1'b0, 0, 1, 0, 0, 3'd0, '0, "R8 nm ext");
    step(4'b0000, 1'b0, 0, 0, 1, 0, 3'd0, '0, "R9 ack5");

    // counted trap on watchpoint 0
    wr(3'd4, 16'd3, "R6 load");
    wr(3'd2, 16'h0001, "R6 mode");
    wr(3'd0, 16'h0001, "R6 arm");
    chk_cnt(0, 16'd3, "R10 readback");
    step(4'b0001, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R6 count1");
    step(4'b0001, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R6 count2");
    chk_cnt(0, 16'd1, "R6 count value");
    step(4'b0001, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R6 terminal");
    step(4'b0000, 1'b1, 0, 0, 1, 0, 3'd0, '0, "R9 ack6");
    step(4'b0001, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R6 after zero");
    chk_cnt(0, 16'd0, "R6 hold zero");

    // masked counter freeze
    wr(3'd4, 16'd2, "R7 reload");
    step(4'b0001, 1'b0, 0, 0, 0, 0, 3'd0, '0, "R7 masked pulse");
    chk_cnt(0, 16'd2, "R7 frozen");

    // write collides with pulse
    step(4'b0001, 1'b1, 0, 0, 0, 1, 3'd4, 16'd5, "R12 collide");
    chk_cnt(0, 16'd5, "R12 write wins");

    // counter 1 in immediate mode keeps its value
    wr(3'd5, 16'd7, "R6 load c1");
    step(4'b0010, 1'b1, 0, 0, 0, 0, 3'd0, '0, "R6 c1 immediate");
    chk_cnt(1, 16'd7, "R10 c1 readback");

    // ack colliding with a new hit
    step(4'b0000, 1'b1, 0, 1, 0, 0, 3'd0, '0, "R8 nm set");
    step(4'b0000, 1'b1, 0, 1, 1, 0, 3'd0, '0, "R9 ack with hit");
    step(4'b0000, 1'b1, 0, 0, 1, 0, 3'd0, '0, "R9 final ack");

    @(negedge clk);
    wait (sb_q.size() == 0);
    @(negedge clk);
    summary();
    $finish;
  end
endmodule